// File: doc/BRIEF.md
# Lane-Partitioned Saturating Vector Adder

The block adds or subtracts two 128-bit vectors that are cut into independent lanes. A 3-bit arrangement code picks the element width (8, 16, 32 or 64 bits) and whether the operation covers only the low 64 bits or the whole 128 bits. This gives seven usable forms. No carry or borrow crosses from one lane into the next. Each lane either wraps modulo 2^n or saturates. Saturation is signed or unsigned, chosen at run time together with add or subtract.

Operands enter through a valid/ready handshake and leave through a second one. A transfer happens on a rising edge where valid and ready are both high. The input side is ready whenever the output register is empty or being drained in the same cycle. When the consumer holds `out_ready` low, the result stays put and intake stalls. A sticky flag records that some active lane clamped. It stays set until the plain `sat_clr` control input is pulsed.

Top module: `simd_sat_addsub`

## Requirements
- R1: `in_arr[2:1]` selects the element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. `in_arr[0]`=1 selects 128-bit operation and 0 selects the low 64 bits only. Code 3'b110 behaves exactly as 3'b111 (two 64-bit lanes).
- R2: With `in_sat`=0, every lane returns (a+b) mod 2^n, and no carry passes into the neighbouring lane.
- R3: With `in_sub`=1, every lane computes a-b instead of a+b, again with no borrow across lanes.
- R4: With `in_sat`=1 and `in_signed`=1, a lane whose true result lies outside -2^(n-1)..2^(n-1)-1 returns the nearer of those limits.
- R5: With `in_sat`=1 and `in_signed`=0, a lane whose result exceeds 2^n-1 returns 2^n-1, and a subtraction that would go below zero returns 0.
- R6: For 64-bit forms, result bits 127:64 are zero, and the upper operand bits never set the saturation flag.
- R7: `sat_flag` rises on the edge that accepts an operation in which any active lane clamped. It then holds until a cycle with `sat_clr`=1 and no such clamp. A new clamp wins over a clear in the same cycle.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted operation appears on `out_data` with `out_valid`=1 one edge later. While `out_valid`=1 and `out_ready`=0, `out_data` holds steady.
- R9: After reset, `out_valid`=0, `out_data`=0 and `sat_flag`=0.
- R10: With `in_sat`=0, `in_signed` has no effect on the result, and the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand |
| in_arr | input | 3 | Arrangement code (element width, total width) |
| in_sub | input | 1 | 1 = subtract, 0 = add |
| in_sat | input | 1 | 1 = saturate, 0 = wrap |
| in_signed | input | 1 | 1 = signed limits, 0 = unsigned limits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 128 | Lane-wise result |
| sat_flag | output | 1 | Sticky clamp indicator |
| sat_clr | input | 1 | Clears the sticky flag |

## Verification
The bench targets lane boundaries with all-ones and all-zeros patterns. A design that leaks a carry would corrupt the neighbouring lane. The bench probes the exact signed and unsigned limits in both directions, including unsigned subtract below zero. A wrong clamp there would return a wrapped value or the wrong limit, such as the maximum in place of zero. It drives 64-bit forms with large upper operands, where a faulty design would leave upper bits nonzero or raise the flag. Random back-pressure catches a result register that drops or changes data while the consumer stalls.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  typedef logic [2:0] arr_t;
  typedef enum logic [1:0] {ESZ_8 = 2'd0, ESZ_16 = 2'd1, ESZ_32 = 2'd2, ESZ_64 = 2'd3} esz_e;

  function automatic esz_e arr_esz(input arr_t code);
    return esz_e'(code[2:1]);
  endfunction

  // 64-bit elements exist only in the full-width form.
  function automatic logic arr_full(input arr_t code);
    return code[0] | (code[2:1] == 2'd3);
  endfunction
endpackage

// File: rtl/vlane_chunk_adder.sv
module vlane_chunk_adder #(
  parameter int CHUNK_W = 8,
  parameter int NCHUNK  = 16,
  localparam int IDX_W  = $clog2(NCHUNK),
  localparam int W      = CHUNK_W * NCHUNK
) (
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  vlane_pkg::esz_e     esz,
  input  logic                sub,
  output logic [W-1:0]        sum,
  output logic [NCHUNK-1:0]   cout,
  output logic [NCHUNK-1:0]   amsb,
  output logic [NCHUNK-1:0]   bmsb
);
  logic [IDX_W-1:0] lmask;
  logic [W-1:0]     bx;
  logic [CHUNK_W:0] part;
  logic             carry;
  logic             cin;

  assign lmask = IDX_W'((32'd1 << esz) - 32'd1);
  assign bx    = sub ? ~b : b;

  // Ripple across chunks; a chunk that starts a lane takes the op carry-in.
  always_comb begin
    carry = 1'b0;
    cin   = 1'b0;
    part  = '0;
    sum   = '0;
    cout  = '0;
    amsb  = '0;
    bmsb  = '0;
    for (int i = 0; i < NCHUNK; i++) begin
      cin  = ((IDX_W'(i) & lmask) == '0) ? sub : carry;
      part = {1'b0, a[i*CHUNK_W +: CHUNK_W]} + {1'b0, bx[i*CHUNK_W +: CHUNK_W]}
           + (CHUNK_W+1)'(cin);
      sum[i*CHUNK_W +: CHUNK_W] = part[CHUNK_W-1:0];
      carry   = part[CHUNK_W];
      cout[i] = carry;
      amsb[i] = a[i*CHUNK_W + CHUNK_W - 1];
      bmsb[i] = bx[i*CHUNK_W + CHUNK_W - 1];
    end
  end
endmodule

// File: rtl/vlane_clamp.sv
module vlane_clamp #(
  parameter int CHUNK_W = 8,
  parameter int NCHUNK  = 16,
  localparam int IDX_W  = $clog2(NCHUNK),
  localparam int W      = CHUNK_W * NCHUNK
) (
  input  logic [W-1:0]        sum,
  input  logic [NCHUNK-1:0]   cout,
  input  logic [NCHUNK-1:0]   amsb,
  input  logic [NCHUNK-1:0]   bmsb,
  input  vlane_pkg::esz_e     esz,
  input  logic                full,
  input  logic                sub,
  input  logic                sat,
  input  logic                sgn,
  output logic [W-1:0]        res,
  output logic                any_clamp
);
  logic [IDX_W-1:0]   lmask;
  logic [IDX_W-1:0]   top;
  logic               ovf;
  logic               hi;
  logic               active;
  logic               clamp;
  logic [CHUNK_W-1:0] limit;
  int                 ti;

  assign lmask = IDX_W'((32'd1 << esz) - 32'd1);

  // Each chunk reads the overflow verdict of the top chunk of its lane.
  always_comb begin
    res       = '0;
    any_clamp = 1'b0;
    top = '0; ti = 0; ovf = 1'b0; hi = 1'b0;
    active = 1'b0; clamp = 1'b0; limit = '0;
    for (int i = 0; i < NCHUNK; i++) begin
      top    = IDX_W'(i) | lmask;
      ti     = int'(top);
      if (sgn)
        ovf = (amsb[ti] == bmsb[ti]) && (sum[ti*CHUNK_W + CHUNK_W - 1] != amsb[ti]);
      else
        ovf = sub ? ~cout[ti] : cout[ti];
      hi     = sgn ? ~amsb[ti] : ~sub;
      active = full || (i < NCHUNK/2);
      clamp  = sat && ovf && active;
      limit  = {CHUNK_W{hi}};
      if (sgn && (IDX_W'(i) == top))
        limit[CHUNK_W-1] = ~limit[CHUNK_W-1];
      if (!active)
        res[i*CHUNK_W +: CHUNK_W] = '0;
      else if (clamp)
        res[i*CHUNK_W +: CHUNK_W] = limit;
      else
        res[i*CHUNK_W +: CHUNK_W] = sum[i*CHUNK_W +: CHUNK_W];
      if (clamp)
        any_clamp = 1'b1;
    end
  end
endmodule

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub #(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 8,
  localparam int NCHUNK = DATA_W / CHUNK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [2:0]        in_arr,
  input  logic              in_sub,
  input  logic              in_sat,
  input  logic              in_signed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              sat_flag,
  input  logic              sat_clr
);
  import vlane_pkg::*;

  esz_e              esz;
  logic              full;
  logic [DATA_W-1:0] raw_sum;
  logic [NCHUNK-1:0] c_out;
  logic [NCHUNK-1:0] a_top;
  logic [NCHUNK-1:0] b_top;
  logic [DATA_W-1:0] lane_res;
  logic              clamped;
  logic              accept;

  assign esz      = arr_esz(in_arr);
  assign full     = arr_full(in_arr);
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  vlane_chunk_adder #(.CHUNK_W(CHUNK_W), .NCHUNK(NCHUNK)) u_add (
    .a(in_a), .b(in_b), .esz(esz), .sub(in_sub),
    .sum(raw_sum), .cout(c_out), .amsb(a_top), .bmsb(b_top)
  );

  vlane_clamp #(.CHUNK_W(CHUNK_W), .NCHUNK(NCHUNK)) u_clamp (
    .sum(raw_sum), .cout(c_out), .amsb(a_top), .bmsb(b_top),
    .esz(esz), .full(full), .sub(in_sub), .sat(in_sat), .sgn(in_signed),
    .res(lane_res), .any_clamp(clamped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= lane_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sat_flag <= 1'b0;
    else if (accept && clamped)
      sat_flag <= 1'b1;
    else if (sat_clr)
      sat_flag <= 1'b0;
  end
endmodule

// File: rtl/simd_sat_addsub_chk.sv
module simd_sat_addsub_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_arr,
  input logic              in_sat,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              sat_flag,
  input logic              sat_clr
);
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_accept_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_arr[0] && (in_arr[2:1] != 2'b11)
    |=> out_data[DATA_W-1:DATA_W/2] == '0);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr && !(in_valid && in_ready) |=> !sat_flag);

  p_wrap_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_flag && !(in_valid && in_ready && in_sat) |=> !sat_flag);
endmodule

bind simd_sat_addsub simd_sat_addsub_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_arr(in_arr), .in_sat(in_sat), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .sat_flag(sat_flag),
  .sat_clr(sat_clr)
);

// File: tb/simd_sat_addsub_test.sv
`timescale 1ns/1ps
module simd_sat_addsub_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [127:0] in_a = '0, in_b = '0;
  logic [2:0]   in_arr = '0;
  logic         in_sub = 0, in_sat = 0, in_signed = 0;
  logic         out_valid, out_ready = 1'b1;
  logic [127:0] out_data;
  logic         sat_flag, sat_clr = 1'b0;

  always #2 clk = ~clk;

  simd_sat_addsub uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_arr(in_arr), .in_sub(in_sub),
    .in_sat(in_sat), .in_signed(in_signed), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .sat_flag(sat_flag),
    .sat_clr(sat_clr)
  );

  typedef struct { logic [127:0] data; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit bp_on = 0;
  bit last_clamp;

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: R1 encoding, R2..R5 lane arithmetic, R6 zero upper half.
  function automatic void ref_op(input logic [127:0] a, b, input logic [2:0] arr,
                                 input logic sub, sat, sgn,
                                 output logic [127:0] r, output bit clamp);
    int n, lanes;
    bit full;
    logic signed [66:0] x, y, z, mx, mn;
    n = 8 << arr[2:1];
    full = arr[0] || (arr[2:1] == 2'd3);
    lanes = (full ? 128 : 64) / n;
    r = '0; clamp = 0;
    for (int l = 0; l < lanes; l++) begin
      x = '0; y = '0;
      for (int k = 0; k < n; k++) begin
        x[k] = a[l*n+k];
        y[k] = b[l*n+k];
      end
      if (sgn && x[n-1]) x = x - (67'sd1 <<< n);
      if (sgn && y[n-1]) y = y - (67'sd1 <<< n);
      z = sub ? x - y : x + y;
      if (sat) begin
        if (sgn) begin
          mx = (67'sd1 <<< (n-1)) - 67'sd1;
          mn = -(67'sd1 <<< (n-1));
        end else begin
          mx = (67'sd1 <<< n) - 67'sd1;
          mn = 67'sd0;
        end
        if (z > mx) begin z = mx; clamp = 1; end
        else if (z < mn) begin z = mn; clamp = 1; end
      end
      for (int k = 0; k < n; k++) r[l*n+k] = z[k];
    end
  endfunction

  task automatic send(input logic [127:0] a, b, input logic [2:0] arr,
                      input logic sub, sat, sgn, input string tag);
    exp_t e;
    @(negedge clk);
    in_a = a; in_b = b; in_arr = arr;
    in_sub = sub; in_sat = sat; in_signed = sgn;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    ref_op(a, b, arr, sub, sat, sgn, e.data, last_clamp);
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: scoreboard pops and R8 hold check under back-pressure.
  bit pstall = 0;
  logic [127:0] pdata;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pstall)
        check(out_valid && out_data == pdata, "R8 hold under stall", out_data, pdata);
      if (out_valid && out_ready) begin
        if (q.size() == 0)
          check(0, "R8 unexpected output", out_data, '0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(out_data == e.data, e.tag, out_data, e.data);
        end
      end
      pstall = out_valid && !out_ready;
      pdata  = out_data;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic flag_check(input logic exp, input string tag);
    check(sat_flag == exp, tag, {127'd0, sat_flag}, {127'd0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid after reset", {127'd0, out_valid}, '0);
    check(out_data == '0, "R9 out_data after reset", out_data, '0);
    flag_check(1'b0, "R9 sat_flag after reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 ready when empty", {127'd0, in_ready}, 128'd1);

    // R2: carries must stop at every lane edge
    for (int c = 0; c < 8; c++)
      send({128{1'b1}}, {16{8'h01}}, 3'(c), 0, 0, 0, "R2 lane carry cut");
    // R3: borrows must stop at every lane edge
    for (int c = 0; c < 8; c++)
      send('0, {16{8'h01}}, 3'(c), 1, 0, 0, "R3 lane borrow cut");
    flag_check(1'b0, "R10 wrap mode never flags");
    send({128{1'b1}}, {16{8'h01}}, 3'd5, 0, 0, 1, "R10 signed select ignored in wrap");
    flag_check(1'b0, "R10 flag after signed wrap");

    // R4 signed limits
    send({8{16'h7FFF}}, {8{16'h0001}}, 3'd3, 0, 1, 1, "R4 signed add to max");
    flag_check(1'b1, "R7 flag set by clamp");
    send({4{32'h8000_0000}}, {4{32'h0000_0001}}, 3'd5, 1, 1, 1, "R4 signed sub to min");
    send({16{8'h80}}, {16{8'h80}}, 3'd1, 0, 1, 1, "R4 signed add to min");
    send({2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'hFFFF_FFFF_FFFF_FFFF}}, 3'd7, 1, 1, 1,
         "R4 signed 64-bit sub to max");
    // R5 unsigned limits
    send({8{16'hFFFF}}, {8{16'h0001}}, 3'd3, 0, 1, 0, "R5 unsigned add to max");
    send('0, {2{64'h1}}, 3'd7, 1, 1, 0, "R5 unsigned sub clamps to zero");
    send({16{8'h10}}, {16{8'h20}}, 3'd1, 1, 1, 0, "R5 unsigned byte sub to zero");
    send({16{8'h10}}, {16{8'h05}}, 3'd1, 1, 1, 0, "R5 unsigned in-range sub");
    flag_check(1'b1, "R7 flag holds without clear");

    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    flag_check(1'b0, "R7 flag cleared");

    // R6: 64-bit forms with saturating upper halves
    send({64'hFFFF_FFFF_FFFF_FFFF, 64'h0102_0304_0506_0708},
         {64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101}, 3'd0, 0, 1, 0,
         "R6 upper half zero 8-bit");
    flag_check(1'b0, "R6 upper lanes do not flag");
    send({64'h7FFF_7FFF_7FFF_7FFF, 64'h0001_0002_0003_0004},
         {64'h7FFF_7FFF_7FFF_7FFF, 64'h0001_0001_0001_0001}, 3'd2, 0, 1, 1,
         "R6 upper half zero 16-bit");
    flag_check(1'b0, "R6 upper lanes do not flag signed");
    // R1: code 6 acts as two 64-bit lanes
    send({64'h1, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h2, 64'h1}, 3'd6, 0, 0, 0,
         "R1 code 6 behaves as full width");

    // Random sweep with back-pressure over all codes and modes
    bp_on = 1;
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 8; m++)
        for (int r = 0; r < 2; r++)
          send({$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom},
               3'(c), m[0], m[1], m[2], "R1 R2 R3 R4 R5 sweep");
    bp_on = 0;

    for (int w = 0; w < 200 && q.size() != 0; w++) @(negedge clk);
    check(q.size() == 0, "R8 all results delivered", 128'(q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule